// File: doc/BRIEF.md
# Duty-Cycle Audio FM Tuning-Word Generator

This block turns a one-bit pulse-width-modulated audio signal into the frequency word for a direct digital synthesizer, so that the synthesized carrier moves away from its rest frequency in proportion to the audio level. Every window of 2^WIN_LOG2 clocks it measures how much of the time the audio pin was high. The measurement is either a plain count of high clocks or a count in which each clock is weighted by a triangle that peaks in the middle of the window. A triangle weights the clocks at the window edges least, which softens the spectral leakage of the measurement.

At the end of a window the measured level is re-centred to a signed value, so that 50 % duty means zero. It is then multiplied by an unsigned deviation gain through a serial shift-and-add loop, one gain bit per clock, and added to the carrier word. The new word is published together with a one-clock strobe and held unchanged until the next window completes. The synthesizer therefore sees a stair-step frequency that is updated once per window.

Top module: `fm_duty_mod`

## Requirements
- R1: During reset and until the first window has been processed, `word_o` is 0 and `word_stb_o` is 0.
- R2: A window is N = 2^WIN_LOG2 clocks long and the first window starts on the first clock after reset. `word_stb_o` is high for exactly one clock per window. It rises GAIN_W clocks after the clock that samples the window's last audio bit.
- R3: In rectangular mode (`shape_tri_i` = 0) each high sample counts 1, and the signed level is (count of high samples) − N/2.
- R4: In triangular mode (`shape_tri_i` = 1) the sample at index i (0-based) within the window has weight i in the first half and N−1−i in the second half. The weight comes from a counter that counts up, holds for one clock at the midpoint, then counts down. The signed level is floor(weighted sum / 2^(WIN_LOG2−2)) − (N/2 − 1).
- R5: `shape_tri_i` is sampled only on the first clock of each window. A change in the middle of a window has no effect on that window's result and takes effect from the next window.
- R6: The published word is (carrier + level × gain) mod 2^TW_W. The level is signed, `gain_i` is unsigned, and the product is sign-extended to TW_W bits.
- R7: `carrier_i` and `gain_i` are sampled on the clock that samples the window's last audio bit. Their values at other times have no effect.
- R8: `word_o` changes only in the clock in which `word_stb_o` is high. It holds its value between strobes.
- R9: An audio input that is high for the whole window gives level +N/2 in rectangular mode and +(N/2−1) in triangular mode. An input that is low for the whole window gives −N/2 and −(N/2−1) respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| audio_pwm_i | input | 1 | Pulse-width-modulated audio bit |
| carrier_i | input | TW_W | Carrier tuning word at rest |
| gain_i | input | GAIN_W | Unsigned deviation gain |
| shape_tri_i | input | 1 | Window shape: 0 rectangular, 1 triangular |
| word_o | output | TW_W | Tuning word for the synthesizer |
| word_stb_o | output | 1 | One-clock pulse when `word_o` is updated |

## Verification
The audio pin is driven with constant duty patterns of several periods. A 3/4 duty pattern whose period divides the window checks the rectangular count against a hand value. Steady high and steady low inputs set the extreme levels and the sign handling of the product, including the largest gain with the most negative level. Patterns of odd period, not aligned to the window, run the triangular weights over every phase, which a plain count cannot tell apart. Changes of the shape select and the carrier in the middle of a window tell whether each is sampled at the window edge required.

// File: rtl/fm_duty_mod.sv
module fm_duty_mod #(
  parameter int WIN_LOG2 = 10,
  parameter int TW_W     = 32,
  parameter int GAIN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              audio_pwm_i,
  input  logic [TW_W-1:0]   carrier_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              shape_tri_i,
  output logic [TW_W-1:0]   word_o,
  output logic              word_stb_o
);
  localparam int N     = 1 << WIN_LOG2;
  localparam int HALF  = N / 2;
  localparam int ACC_W = 2 * WIN_LOG2;
  localparam int AUD_W = WIN_LOG2 + 1;
  localparam int BIT_W = (GAIN_W > 1) ? $clog2(GAIN_W) : 1;
  localparam logic [WIN_LOG2-1:0] MID  = WIN_LOG2'(HALF - 1);
  localparam logic [BIT_W-1:0]    LAST_BIT = BIT_W'(GAIN_W - 1);

  logic [WIN_LOG2-1:0] cnt;
  logic [WIN_LOG2-2:0] wt;
  logic                mode_q;
  logic [ACC_W-1:0]    acc;
  logic                busy;
  logic [BIT_W-1:0]    mbit;
  logic [GAIN_W-1:0]   gsh;
  logic [TW_W-1:0]     addend;
  logic [TW_W-1:0]     prod;

  wire first    = (cnt == '0);
  wire last     = (cnt == '1);
  wire mode_eff = first ? shape_tri_i : mode_q;

  wire [ACC_W-1:0] add     = !audio_pwm_i ? '0 : (mode_eff ? ACC_W'(wt) : ACC_W'(1));
  wire [ACC_W-1:0] acc_sum = (first ? '0 : acc) + add;

  wire [AUD_W-1:0] lvl_rect = AUD_W'(acc_sum) - AUD_W'(HALF);
  wire [AUD_W-1:0] lvl_tri  = AUD_W'(acc_sum >> (WIN_LOG2 - 2)) - AUD_W'(HALF - 1);
  wire [AUD_W-1:0] lvl      = mode_eff ? lvl_tri : lvl_rect;

  wire [TW_W-1:0] prod_nxt = prod + (gsh[0] ? addend : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wt     <= '0;
      mode_q <= 1'b0;
      acc    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      acc <= acc_sum;
      if (first) mode_q <= shape_tri_i;
      if (last)                            wt <= '0;
      else if (!cnt[WIN_LOG2-1] && cnt != MID) wt <= wt + 1'b1;
      else if (cnt != MID)                 wt <= wt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      mbit       <= '0;
      gsh        <= '0;
      addend     <= '0;
      prod       <= '0;
      word_o     <= '0;
      word_stb_o <= 1'b0;
    end else begin
      word_stb_o <= 1'b0;
      if (last) begin
        busy   <= 1'b1;
        mbit   <= '0;
        gsh    <= gain_i;
        addend <= TW_W'($signed(lvl));
        prod   <= carrier_i;
      end else if (busy) begin
        prod   <= prod_nxt;
        addend <= addend << 1;
        gsh    <= gsh >> 1;
        mbit   <= mbit + 1'b1;
        if (mbit == LAST_BIT) begin
          busy       <= 1'b0;
          word_o     <= prod_nxt;
          word_stb_o <= 1'b1;
        end
      end
    end
  end

  p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
    word_stb_o |=> !word_stb_o);

  p_stb_phase_r2: assert property (@(posedge clk) disable iff (rst)
    word_stb_o |-> (int'(cnt) == GAIN_W));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !word_stb_o |-> $stable(word_o));

  p_mode_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt > 1) |-> $stable(mode_q));

  p_wt_zero_r4: assert property (@(posedge clk) disable iff (rst)
    first |-> (wt == '0));

  p_rect_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !first) |-> (acc <= ACC_W'(cnt)));
endmodule

// File: tb/tb_fm_duty_mod.sv
module tb_fm_duty_mod;
  localparam int WIN_LOG2 = 10;
  localparam int TW_W     = 32;
  localparam int GAIN_W   = 8;
  localparam int N        = 1 << WIN_LOG2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pin = 1'b0;
  logic [TW_W-1:0]   carrier = '0;
  logic [GAIN_W-1:0] gain = '0;
  logic              tri_sel = 1'b0;
  logic [TW_W-1:0]   word_o;
  logic              word_stb_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R3";
  int per = 4;
  int hi  = 3;
  int pcnt = 0;

  fm_duty_mod #(.WIN_LOG2(WIN_LOG2), .TW_W(TW_W), .GAIN_W(GAIN_W)) dut (
    .clk(clk), .rst(rst), .audio_pwm_i(pin), .carrier_i(carrier),
    .gain_i(gain), .shape_tri_i(tri_sel), .word_o(word_o), .word_stb_o(word_stb_o)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    pcnt = pcnt + 1;
    pin  = ((pcnt % per) < hi);
  end

  int idx, sum, pend, aud, w;
  bit mode_w;
  longint car_s, gn_s;
  logic [TW_W-1:0] exp_word;
  bit exp_stb;

  always @(posedge clk) begin
    if (rst) begin
      idx = 0; sum = 0; pend = 0; exp_word = '0; exp_stb = 0; mode_w = 0;
    end else begin
      exp_stb = 0;
      if (pend > 0) begin
        pend = pend - 1;
        if (pend == 0) begin
          exp_word = TW_W'(car_s + longint'(aud) * gn_s);
          exp_stb = 1;
        end
      end
      if (idx == 0) begin
        mode_w = tri_sel;
        sum = 0;
      end
      if (mode_w) w = (idx < N/2) ? idx : (N - 1 - idx);
      else        w = 1;
      if (pin) sum = sum + w;
      if (idx == N - 1) begin
        aud   = mode_w ? (sum / (N/4)) - (N/2 - 1) : sum - N/2;
        car_s = longint'(carrier);
        gn_s  = longint'(gain);
        pend  = GAIN_W;
      end
      idx = (idx + 1) % N;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (word_stb_o !== exp_stb) begin
        errors++;
        $display("FAIL R2 strobe act=%0b exp=%0b", word_stb_o, exp_stb);
      end
      if (word_o !== exp_word) begin
        errors++;
        $display("FAIL %s word act=%h exp=%h", exp_stb ? cur_req : "R8", word_o, exp_word);
      end
    end
  end

  task automatic chk(input string req, input logic [TW_W-1:0] act, input logic [TW_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!word_stb_o);
  endtask

  task automatic settle();
    wait_stb();
    wait_stb();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", {31'd0, word_stb_o}, 32'd0);
    chk("R1", word_o, 32'd0);
    carrier = 32'd1000; gain = 8'd3; tri_sel = 0; per = 4; hi = 3;
    rst = 1'b0;
    repeat (N - 2) @(negedge clk);
    chk("R1", word_o, 32'd0);
    // R3: 3/4 duty rectangular -> level 256
    cur_req = "R3";
    wait_stb();
    chk("R3", word_o, 32'd1768);
    wait_stb();
    chk("R3", word_o, 32'd1768);
    // R9: extremes rectangular
    cur_req = "R9";
    carrier = 32'd0; gain = 8'd5; per = 1; hi = 1;
    settle();
    chk("R9", word_o, 32'd2560);
    hi = 0;
    settle();
    chk("R9", word_o, 32'hFFFFF600);
    // R4/R9: triangular all high -> level 511
    cur_req = "R4";
    tri_sel = 1; carrier = 32'h1000; gain = 8'd2; hi = 1;
    settle();
    chk("R4", word_o, 32'd5118);
    hi = 0;
    settle();
    chk("R9", word_o, 32'h1000 - 32'd1022);
    // R4: unaligned pattern, model reference
    per = 3; hi = 1; gain = 8'd7;
    settle();
    chk("R4", {31'd0, word_stb_o}, 32'd1);
    // R5: shape change mid-window
    cur_req = "R5";
    per = 1; hi = 1; gain = 8'd1; carrier = 32'd0;
    settle();
    repeat (100) @(negedge clk);
    tri_sel = 0;
    wait_stb();
    chk("R5", word_o, 32'd511);
    wait_stb();
    chk("R5", word_o, 32'd512);
    // R7: carrier change mid-window is used at window end
    cur_req = "R7";
    repeat (500) @(negedge clk);
    carrier = 32'd40000;
    wait_stb();
    chk("R7", word_o, 32'd40512);
    // R6: max gain, most negative level
    cur_req = "R6";
    carrier = 32'h10000; gain = 8'd255; hi = 0;
    settle();
    chk("R6", word_o, 32'hFFFF0200);
    // R3: unaligned rectangular pattern, model reference
    cur_req = "R3";
    per = 5; hi = 2; gain = 8'd9; carrier = 32'd77;
    settle();
    chk("R3", {31'd0, word_stb_o}, 32'd1);
    repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule